// File: doc/BRIEF.md
# Order Price Collar and Quote Age Gate

This block sits in an order path and judges each outgoing limit order against the most recent market reference it has been given. The reference is a snapshot holding four values: a last trade price, a best bid, a best ask and the time the snapshot was taken. Every order gets a verdict one clock after it is presented. The verdict is either pass or reject, and a reject carries a reason code.

Three rules apply to each order. The first is a side-dependent collar around the last trade price. A buy may not sit more than a set number of basis points above that price, and a sell may not sit more than that many basis points below it. The second is a quote-age limit: a reference that is too old disqualifies the order. The third is an absolute tick band that the limit price must stay inside, stretching from the bid on the low side to the ask on the high side.

The three settings arrive as static configuration inputs. The current time comes from a free-running counter outside the block. Snapshots are loaded by a one-cycle strobe. A snapshot that is loaded in the same cycle as an order is applied only to later orders.

Top module: `price_collar_check`

## Requirements
- R1: After reset `res_valid` is low, and no reference snapshot is held until the first `snap_valid` strobe.
- R2: An order presented with `ord_valid` high at a clock edge produces exactly one `res_valid` pulse one cycle later, and `res_valid` is never high otherwise.
- R3: While no snapshot has been loaded since reset, every order is rejected with reason code 1 (stale).
- R4: Age is `now_ts - snapshot timestamp` taken modulo 2^TS_W, so a counter wrap is handled. An age above `cfg_max_age` gives reason 1. An age equal to the limit passes the age rule.
- R5: A buy (`ord_side` = 0) is rejected with reason 2 (collar) when price x 10000 > last x (10000 + `cfg_collar_bps`). Equality passes.
- R6: A sell (`ord_side` = 1) is rejected with reason 2 when price x 10000 < last x (10000 - `cfg_collar_bps`). When `cfg_collar_bps` is 10000 or more, a sell has no lower collar limit.
- R7: An order is rejected with reason 3 (band) when its price is below bid - `cfg_band` or above ask + `cfg_band`. Both computations are made without wrap.
- R8: When several rules are violated, the reason reported is the first in this order: stale (1), collar (2), band (3). `res_pass` is high exactly when the reason is 0.
- R9: A `snap_valid` strobe in the same cycle as an order does not affect that order. It applies from the next order on.
- R10: A `snap_valid` strobe replaces all four snapshot fields together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_collar_bps | input | BPS_W | Collar width in basis points |
| cfg_band | input | PRICE_W | Tick band around bid and ask |
| cfg_max_age | input | TS_W | Largest acceptable snapshot age |
| now_ts | input | TS_W | Free-running timestamp |
| snap_valid | input | 1 | Load strobe for a new snapshot |
| snap_last | input | PRICE_W | Last trade price |
| snap_bid | input | PRICE_W | Best bid |
| snap_ask | input | PRICE_W | Best ask |
| snap_ts | input | TS_W | Snapshot timestamp |
| ord_valid | input | 1 | Order present |
| ord_side | input | 1 | 0 buy, 1 sell |
| ord_price | input | PRICE_W | Order limit price |
| res_valid | output | 1 | Verdict present |
| res_pass | output | 1 | Order accepted |
| res_reason | output | 2 | 0 none, 1 stale, 2 collar, 3 band |

## Verification
The assertions assume that the configuration inputs do not change in the cycle between an order and its verdict. They also assume that `ord_price`, `ord_side` and `now_ts` are sampled only at the order's own edge. The bench meets these assumptions by setting the configuration only while no order is in flight, and by driving every input at the falling edge. It also keeps `cfg_band` and the snapshot prices small enough that price plus band fits in PRICE_W+1 bits, which is the width the checker uses for its band comparison.

// File: rtl/pcol_pkg.sv
package pcol_pkg;

    localparam int unsigned BPS_UNITY = 10000;

    typedef enum logic [1:0] {
        RSN_NONE   = 2'd0,
        RSN_STALE  = 2'd1,
        RSN_COLLAR = 2'd2,
        RSN_BAND   = 2'd3
    } reason_e;

    typedef enum logic {
        SIDE_BUY  = 1'b0,
        SIDE_SELL = 1'b1
    } side_e;

    typedef struct packed {
        logic stale;
        logic collar;
        logic band;
    } viol_t;

    function automatic reason_e pick_reason(input viol_t v);
        if (v.stale)       return RSN_STALE;
        else if (v.collar) return RSN_COLLAR;
        else if (v.band)   return RSN_BAND;
        else               return RSN_NONE;
    endfunction

endpackage

// File: rtl/pcol_snapshot.sv
module pcol_snapshot #(
    parameter int PRICE_W = 32,
    parameter int TS_W    = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [PRICE_W-1:0] in_last,
    input  logic [PRICE_W-1:0] in_bid,
    input  logic [PRICE_W-1:0] in_ask,
    input  logic [TS_W-1:0]    in_ts,
    output logic               have,
    output logic [PRICE_W-1:0] ref_last,
    output logic [PRICE_W-1:0] ref_bid,
    output logic [PRICE_W-1:0] ref_ask,
    output logic [TS_W-1:0]    ref_ts
);
    always_ff @(posedge clk) begin
        if (rst) begin
            have     <= 1'b0;
            ref_last <= '0;
            ref_bid  <= '0;
            ref_ask  <= '0;
            ref_ts   <= '0;
        end else if (load) begin
            have     <= 1'b1;
            ref_last <= in_last;
            ref_bid  <= in_bid;
            ref_ask  <= in_ask;
            ref_ts   <= in_ts;
        end
    end
endmodule

// File: rtl/pcol_age.sv
module pcol_age #(
    parameter int TS_W = 32
) (
    input  logic            have,
    input  logic [TS_W-1:0] now_ts,
    input  logic [TS_W-1:0] ref_ts,
    input  logic [TS_W-1:0] max_age,
    output logic            stale
);
    logic [TS_W-1:0] age;

    always_comb begin
        age   = now_ts - ref_ts;
        stale = !have || (age > max_age);
    end
endmodule

// File: rtl/pcol_collar.sv
module pcol_collar #(
    parameter int PRICE_W = 32,
    parameter int BPS_W   = 16
) (
    input  logic               side,
    input  logic [PRICE_W-1:0] price,
    input  logic [PRICE_W-1:0] ref_last,
    input  logic [BPS_W-1:0]   bps,
    output logic               violate
);
    import pcol_pkg::*;

    localparam int MULT_W = ((BPS_W > 14) ? BPS_W : 14) + 1;
    localparam int PROD_W = PRICE_W + MULT_W;

    logic [MULT_W-1:0] hi_mult;
    logic [MULT_W-1:0] lo_mult;
    logic [PROD_W-1:0] scaled_px;
    logic [PROD_W-1:0] hi_bound;
    logic [PROD_W-1:0] lo_bound;

    always_comb begin
        hi_mult = MULT_W'(BPS_UNITY) + MULT_W'(bps);
        if (MULT_W'(bps) >= MULT_W'(BPS_UNITY))
            lo_mult = '0;
        else
            lo_mult = MULT_W'(BPS_UNITY) - MULT_W'(bps);

        scaled_px = PROD_W'(price) * PROD_W'(BPS_UNITY);
        hi_bound  = PROD_W'(ref_last) * PROD_W'(hi_mult);
        lo_bound  = PROD_W'(ref_last) * PROD_W'(lo_mult);

        if (side == SIDE_BUY)
            violate = scaled_px > hi_bound;
        else
            violate = scaled_px < lo_bound;
    end
endmodule

// File: rtl/pcol_band.sv
module pcol_band #(
    parameter int PRICE_W = 32
) (
    input  logic [PRICE_W-1:0] price,
    input  logic [PRICE_W-1:0] ref_bid,
    input  logic [PRICE_W-1:0] ref_ask,
    input  logic [PRICE_W-1:0] band,
    output logic               violate
);
    localparam int EXT_W = PRICE_W + 1;

    logic [EXT_W-1:0] px_plus_band;
    logic [EXT_W-1:0] ask_plus_band;
    logic             below;
    logic             above;

    always_comb begin
        px_plus_band  = EXT_W'(price) + EXT_W'(band);
        ask_plus_band = EXT_W'(ref_ask) + EXT_W'(band);
        below         = px_plus_band < EXT_W'(ref_bid);
        above         = EXT_W'(price) > ask_plus_band;
        violate       = below || above;
    end
endmodule

// File: rtl/price_collar_check.sv
module price_collar_check #(
    parameter int PRICE_W = 32,
    parameter int TS_W    = 32,
    parameter int BPS_W   = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [BPS_W-1:0]   cfg_collar_bps,
    input  logic [PRICE_W-1:0] cfg_band,
    input  logic [TS_W-1:0]    cfg_max_age,
    input  logic [TS_W-1:0]    now_ts,
    input  logic               snap_valid,
    input  logic [PRICE_W-1:0] snap_last,
    input  logic [PRICE_W-1:0] snap_bid,
    input  logic [PRICE_W-1:0] snap_ask,
    input  logic [TS_W-1:0]    snap_ts,
    input  logic               ord_valid,
    input  logic               ord_side,
    input  logic [PRICE_W-1:0] ord_price,
    output logic               res_valid,
    output logic               res_pass,
    output logic [1:0]         res_reason
);
    import pcol_pkg::*;

    logic               have;
    logic [PRICE_W-1:0] ref_last;
    logic [PRICE_W-1:0] ref_bid;
    logic [PRICE_W-1:0] ref_ask;
    logic [TS_W-1:0]    ref_ts;
    viol_t              viol;
    reason_e            reason_d;

    pcol_snapshot #(.PRICE_W(PRICE_W), .TS_W(TS_W)) u_snap (
        .clk      (clk),
        .rst      (rst),
        .load     (snap_valid),
        .in_last  (snap_last),
        .in_bid   (snap_bid),
        .in_ask   (snap_ask),
        .in_ts    (snap_ts),
        .have     (have),
        .ref_last (ref_last),
        .ref_bid  (ref_bid),
        .ref_ask  (ref_ask),
        .ref_ts   (ref_ts)
    );

    pcol_age #(.TS_W(TS_W)) u_age (
        .have    (have),
        .now_ts  (now_ts),
        .ref_ts  (ref_ts),
        .max_age (cfg_max_age),
        .stale   (viol.stale)
    );

    pcol_collar #(.PRICE_W(PRICE_W), .BPS_W(BPS_W)) u_collar (
        .side     (ord_side),
        .price    (ord_price),
        .ref_last (ref_last),
        .bps      (cfg_collar_bps),
        .violate  (viol.collar)
    );

    pcol_band #(.PRICE_W(PRICE_W)) u_band (
        .price   (ord_price),
        .ref_bid (ref_bid),
        .ref_ask (ref_ask),
        .band    (cfg_band),
        .violate (viol.band)
    );

    assign reason_d = pick_reason(viol);

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid  <= 1'b0;
            res_pass   <= 1'b0;
            res_reason <= RSN_NONE;
        end else begin
            res_valid <= ord_valid;
            if (ord_valid) begin
                res_pass   <= (reason_d == RSN_NONE);
                res_reason <= reason_d;
            end
        end
    end
endmodule

// File: rtl/price_collar_check_sva.sv
module price_collar_check_sva #(
    parameter int PRICE_W = 32,
    parameter int TS_W    = 32,
    parameter int BPS_W   = 16
) (
    input logic               clk,
    input logic               rst,
    input logic [BPS_W-1:0]   cfg_collar_bps,
    input logic [PRICE_W-1:0] cfg_band,
    input logic [TS_W-1:0]    cfg_max_age,
    input logic [TS_W-1:0]    now_ts,
    input logic               snap_valid,
    input logic [PRICE_W-1:0] snap_last,
    input logic [PRICE_W-1:0] snap_bid,
    input logic [PRICE_W-1:0] snap_ask,
    input logic [TS_W-1:0]    snap_ts,
    input logic               ord_valid,
    input logic               ord_side,
    input logic [PRICE_W-1:0] ord_price,
    input logic               res_valid,
    input logic               res_pass,
    input logic [1:0]         res_reason
);
    localparam int EXT_W = PRICE_W + 1;

    logic               seen;
    logic [PRICE_W-1:0] c_bid;
    logic [PRICE_W-1:0] c_ask;
    logic [TS_W-1:0]    c_ts;
    logic [TS_W-1:0]    c_age;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen  <= 1'b0;
            c_bid <= '0;
            c_ask <= '0;
            c_ts  <= '0;
        end else if (snap_valid) begin
            seen  <= 1'b1;
            c_bid <= snap_bid;
            c_ask <= snap_ask;
            c_ts  <= snap_ts;
        end
    end

    assign c_age = now_ts - c_ts;

    // R2: one verdict per order, one cycle later
    a_r2_verdict_follows: assert property (@(posedge clk) disable iff (rst)
        ord_valid |=> res_valid);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !ord_valid |=> !res_valid);

    // R8: pass flag agrees with reason code
    a_r8_pass_reason: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_pass == (res_reason == 2'd0)));

    // R3: no snapshot held yet means stale
    a_r3_no_snap_stale: assert property (@(posedge clk) disable iff (rst)
        (ord_valid && !seen) |=> (res_reason == 2'd1));

    // R4: snapshot older than the limit means stale
    a_r4_age_stale: assert property (@(posedge clk) disable iff (rst)
        (ord_valid && seen && (c_age > cfg_max_age)) |=> (res_reason == 2'd1));

    // R7: an accepted order lies inside the band
    a_r7_pass_in_band: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_pass) |->
            ((EXT_W'($past(ord_price)) + EXT_W'($past(cfg_band)) >= EXT_W'($past(c_bid))) &&
             (EXT_W'($past(ord_price)) <= EXT_W'($past(c_ask)) + EXT_W'($past(cfg_band)))));
endmodule

bind price_collar_check price_collar_check_sva #(
    .PRICE_W(PRICE_W), .TS_W(TS_W), .BPS_W(BPS_W)
) u_sva (.*);

// File: tb/price_collar_check_tb.sv
module price_collar_check_tb;
    localparam int PRICE_W = 32;
    localparam int TS_W    = 32;
    localparam int BPS_W   = 16;

    logic               clk = 1'b0;
    logic               rst;
    logic [BPS_W-1:0]   cfg_collar_bps;
    logic [PRICE_W-1:0] cfg_band;
    logic [TS_W-1:0]    cfg_max_age;
    logic [TS_W-1:0]    now_ts;
    logic               snap_valid;
    logic [PRICE_W-1:0] snap_last;
    logic [PRICE_W-1:0] snap_bid;
    logic [PRICE_W-1:0] snap_ask;
    logic [TS_W-1:0]    snap_ts;
    logic               ord_valid;
    logic               ord_side;
    logic [PRICE_W-1:0] ord_price;
    logic               res_valid;
    logic               res_pass;
    logic [1:0]         res_reason;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    price_collar_check #(.PRICE_W(PRICE_W), .TS_W(TS_W), .BPS_W(BPS_W)) u_dut (.*);

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load_snap(input int last, input int bid, input int ask, input int ts);
        @(negedge clk);
        snap_valid = 1'b1;
        snap_last = last; snap_bid = bid; snap_ask = ask; snap_ts = ts;
        @(negedge clk);
        snap_valid = 1'b0;
    endtask

    task automatic order(input string req, input bit side, input int price, input int exp_rsn);
        @(negedge clk);
        ord_valid = 1'b1; ord_side = side; ord_price = price;
        @(posedge clk); #1;
        ord_valid = 1'b0;
        check(req, int'(res_valid), 1);
        check(req, int'(res_reason), exp_rsn);
        check(req, int'(res_pass), int'(exp_rsn == 0));
    endtask

    task automatic t_reset();
        rst = 1'b1; snap_valid = 0; ord_valid = 0; ord_side = 0; ord_price = 0;
        snap_last = 0; snap_bid = 0; snap_ask = 0; snap_ts = 0;
        cfg_collar_bps = 100; cfg_band = 200; cfg_max_age = 50; now_ts = 1000;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        check("R1 reset res_valid", int'(res_valid), 0);
    endtask

    task automatic t_no_snapshot();
        order("R3 no snapshot buy", 0, 10000, 1);
        order("R3 no snapshot sell", 1, 10000, 1);
        @(posedge clk); #1;
        check("R2 single pulse", int'(res_valid), 0);
    endtask

    task automatic t_buy_collar();
        load_snap(10000, 9990, 10010, 1000);
        cfg_band = 200; now_ts = 1000;
        order("R5 buy at limit", 0, 10100, 0);
        order("R5 buy over limit", 0, 10101, 2);
        order("R5 sell high no collar", 1, 10150, 0);
    endtask

    task automatic t_sell_collar();
        order("R6 sell at limit", 1, 9900, 0);
        order("R6 sell under limit", 1, 9899, 2);
        order("R6 buy low no collar", 0, 9850, 0);
        cfg_collar_bps = 12000; cfg_band = 20000;
        order("R6 sell no lower bound", 1, 1, 0);
        cfg_collar_bps = 100; cfg_band = 200;
    endtask

    task automatic t_band();
        cfg_band = 50;
        order("R7 band upper edge", 0, 10060, 0);
        order("R7 above ask band", 0, 10061, 3);
        order("R7 band lower edge", 1, 9940, 0);
        order("R7 below bid band", 1, 9939, 3);
        cfg_band = 200;
    endtask

    task automatic t_age();
        now_ts = 1050;
        order("R4 age at limit", 0, 10000, 0);
        now_ts = 1051;
        order("R4 age over limit", 0, 10000, 1);
        load_snap(10000, 9990, 10010, 32'hFFFF_FFF0);
        now_ts = 32'h22;
        order("R4 wrap age at limit", 0, 10000, 0);
        now_ts = 32'h23;
        order("R4 wrap age over", 0, 10000, 1);
        load_snap(10000, 9990, 10010, 1000);
        now_ts = 1000;
    endtask

    task automatic t_priority();
        cfg_band = 50;
        now_ts = 1100;
        order("R8 stale over collar", 0, 10200, 1);
        now_ts = 1000;
        order("R8 collar over band", 0, 10200, 2);
        order("R8 band only buy", 0, 10080, 3);
        order("R8 band only sell", 1, 9930, 3);
        cfg_band = 200;
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        snap_valid = 1; snap_last = 5000; snap_bid = 4990; snap_ask = 5010; snap_ts = 1000;
        ord_valid = 1; ord_side = 0; ord_price = 10100;
        @(posedge clk); #1;
        snap_valid = 0; ord_valid = 0;
        check("R9 same-cycle old ref", int'(res_reason), 0);
        cfg_band = 10000;
        order("R9 R10 new last used", 0, 10100, 2);
        cfg_band = 0;
        order("R10 new bid used", 1, 4989, 3);
        order("R10 new ask used", 0, 5010, 0);
    endtask

    initial begin
        t_reset();
        t_no_snapshot();
        t_buy_collar();
        t_sell_collar();
        t_band();
        t_age();
        t_priority();
        t_same_cycle();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule